// File: doc/BRIEF.md
# Decode-Stage Branch Operand Forwarder

This block picks where the source operand of a branch comes from while the branch sits in the decode stage. Branches there are resolved early by a zero test on one source register. That register may still be waiting to be written by an older instruction in the memory or writeback stage. The block compares the branch's source register number with the destination numbers of those two stages. It then drives the select of a single three-input operand mux. The mux inputs are the register-file read value, the writeback result and the memory-stage result.

The block is purely combinational. It looks only at the one source register that a branch tests, and only at integer register writes; floating-point destinations play no part. When the decode instruction is not a branch, the select rests on the register-file input. A load in the memory stage has no data yet, so the block never selects it. Holding the branch until the load data arrives is left to a separate stall unit.

The register-number width and the treatment of register index zero are parameters. Index zero is either a hardwired constant that is never forwarded, or an ordinary register.

Top module: `brfwd_unit`

## Requirements
- R1: While `id_is_branch` is 0, `fwd_sel` is 2'b00 (register file), whatever the other inputs are.
- R2: `fwd_sel` is 2'b10 (memory-stage value) when the decode instruction is a branch, `id_rs` equals `mem_rd`, `mem_gpr_we` is 1 and `mem_is_load` is 0.
- R3: `fwd_sel` is 2'b01 (writeback value) when the decode instruction is a branch, `id_rs` equals `wb_rd`, `wb_gpr_we` is 1, `wb_rd` differs from `mem_rd`, and R2 does not apply.
- R4: If register zero is hardwired (`ZERO_HW`=1), a destination of 0 never causes forwarding from either stage, so `id_rs`=0 always gives 2'b00.
- R5: When the memory-stage instruction is a load that writes the branch's source register, `fwd_sel` is 2'b00. The writeback stage is not used in its place.
- R6: If `wb_rd` equals `mem_rd`, the writeback stage is never selected, even when `mem_gpr_we` is 0.
- R7: `fwd_sel` never takes the value 2'b11.
- R8: With `ZERO_HW`=0, register index 0 is forwarded from either stage under the same rules as any other index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | AW | Source register number of the decode-stage instruction |
| id_is_branch | input | 1 | Decode-stage instruction is a branch |
| mem_rd | input | AW | Destination register number in the memory stage |
| mem_gpr_we | input | 1 | Memory-stage instruction writes an integer register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | AW | Destination register number in the writeback stage |
| wb_gpr_we | input | 1 | Writeback-stage instruction writes an integer register |
| fwd_sel | output | 2 | Operand mux select: 00 register file, 01 writeback, 10 memory |

## Verification
The bench builds two copies of the block side by side. The first uses the default 5-bit register numbers with index zero hardwired. The second uses 2-bit register numbers with index zero treated as an ordinary register. With only four register numbers, random stimulus gives frequent matches on both stages and frequent cases where `wb_rd` equals `mem_rd`. It also forwards index 0, which exercises the path that the default copy shuts off. Directed cases cover the load in the memory stage, the zero destination and a writeback that is shadowed by an idle memory stage.

// File: rtl/brfwd_pkg.sv
package brfwd_pkg;

   typedef enum logic [1:0] {
      BSEL_RF  = 2'b00,
      BSEL_WB  = 2'b01,
      BSEL_MEM = 2'b10
   } bsel_e;

   localparam int unsigned BSEL_W = 2;

endpackage

// File: rtl/brfwd_stage_match.sv
// Decides whether one older pipeline stage holds a newer value of the
// branch source register.
module brfwd_stage_match #(
   parameter int unsigned AW      = 5,
   parameter bit          ZERO_HW = 1'b1
) (
   input  logic [AW-1:0] src,
   input  logic [AW-1:0] dst,
   input  logic          wr_en,
   input  logic          gate,
   output logic          hit
);

   logic dst_ok;

   generate
      if (ZERO_HW) begin : g_zero_const
         assign dst_ok = |dst;
      end else begin : g_zero_plain
         assign dst_ok = 1'b1;
      end
   endgenerate

   assign hit = gate & wr_en & dst_ok & (src == dst);

endmodule

// File: rtl/brfwd_pick.sv
// Resolves the two stage hits into the mux select. The memory stage is
// newer, so it wins. A memory-stage load has no data yet and yields the
// register file, which leaves the case to the stall unit.
module brfwd_pick
   import brfwd_pkg::*;
(
   input  logic  mem_hit,
   input  logic  mem_load,
   input  logic  wb_hit,
   input  logic  wb_shadowed,
   output bsel_e sel
);

   always_comb begin
      sel = BSEL_RF;
      if (mem_hit) begin
         sel = mem_load ? BSEL_RF : BSEL_MEM;
      end else if (wb_hit && !wb_shadowed) begin
         sel = BSEL_WB;
      end
   end

endmodule

// File: rtl/brfwd_unit.sv
module brfwd_unit
   import brfwd_pkg::*;
#(
   parameter int unsigned AW      = 5,
   parameter bit          ZERO_HW = 1'b1
) (
   input  logic [AW-1:0] id_rs,
   input  logic          id_is_branch,
   input  logic [AW-1:0] mem_rd,
   input  logic          mem_gpr_we,
   input  logic          mem_is_load,
   input  logic [AW-1:0] wb_rd,
   input  logic          wb_gpr_we,
   output logic [1:0]    fwd_sel
);

   localparam int unsigned NREGS = 1 << AW;

   generate
      if (AW < 1 || AW > 8) begin : g_bad_aw
         $error("brfwd_unit: AW must lie in 1..8");
      end
      if (ZERO_HW && NREGS < 2) begin : g_bad_zero
         $error("brfwd_unit: a hardwired zero needs at least two registers");
      end
   endgenerate

   logic  mem_hit;
   logic  wb_hit;
   logic  wb_shadowed;
   bsel_e sel;

   brfwd_stage_match #(.AW(AW), .ZERO_HW(ZERO_HW)) u_mem_match (
      .src   (id_rs),
      .dst   (mem_rd),
      .wr_en (mem_gpr_we),
      .gate  (id_is_branch),
      .hit   (mem_hit)
   );

   brfwd_stage_match #(.AW(AW), .ZERO_HW(ZERO_HW)) u_wb_match (
      .src   (id_rs),
      .dst   (wb_rd),
      .wr_en (wb_gpr_we),
      .gate  (id_is_branch),
      .hit   (wb_hit)
   );

   assign wb_shadowed = (wb_rd == mem_rd);

   brfwd_pick u_pick (
      .mem_hit     (mem_hit),
      .mem_load    (mem_is_load),
      .wb_hit      (wb_hit),
      .wb_shadowed (wb_shadowed),
      .sel         (sel)
   );

   assign fwd_sel = sel;

endmodule

// File: rtl/brfwd_unit_chk.sv
module brfwd_unit_chk #(
   parameter int unsigned AW      = 5,
   parameter bit          ZERO_HW = 1'b1
) (
   input logic [AW-1:0] id_rs,
   input logic          id_is_branch,
   input logic [AW-1:0] mem_rd,
   input logic          mem_gpr_we,
   input logic          mem_is_load,
   input logic [AW-1:0] wb_rd,
   input logic          wb_gpr_we,
   input logic [1:0]    fwd_sel
);

   logic known;
   assign known = !$isunknown({id_rs, id_is_branch, mem_rd, mem_gpr_we,
                               mem_is_load, wb_rd, wb_gpr_we, fwd_sel});

   always_comb begin
      if (known) begin
         a_r1_idle_rf: assert (id_is_branch || fwd_sel == 2'b00);
         a_r7_legal_code: assert (fwd_sel != 2'b11);
         a_r2_mem_source: assert (fwd_sel != 2'b10 ||
            (id_rs == mem_rd && mem_gpr_we && !mem_is_load));
         a_r3_wb_source: assert (fwd_sel != 2'b01 ||
            (id_rs == wb_rd && wb_gpr_we));
         a_r6_wb_shadow: assert (fwd_sel != 2'b01 || wb_rd != mem_rd);
         a_r5_load_held: assert (!(mem_is_load && mem_gpr_we && id_rs == mem_rd)
                                 || fwd_sel == 2'b00);
         a_r4_zero_quiet: assert (!(ZERO_HW && id_rs == '0) || fwd_sel == 2'b00);
      end
   end

endmodule

bind brfwd_unit brfwd_unit_chk #(.AW(AW), .ZERO_HW(ZERO_HW)) u_chk (.*);

// File: tb/brfwd_unit_bench.sv
module brfwd_unit_bench;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [4:0] rs, mrd, wrd;
   logic       br, mwe, mld, wwe;
   logic [1:0] sel_w, sel_n;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   brfwd_unit u_brfwd_unit (
      .id_rs(rs), .id_is_branch(br), .mem_rd(mrd), .mem_gpr_we(mwe),
      .mem_is_load(mld), .wb_rd(wrd), .wb_gpr_we(wwe), .fwd_sel(sel_w)
   );

   brfwd_unit #(.AW(2), .ZERO_HW(1'b0)) u_brfwd_unit_n (
      .id_rs(rs[1:0]), .id_is_branch(br), .mem_rd(mrd[1:0]), .mem_gpr_we(mwe),
      .mem_is_load(mld), .wb_rd(wrd[1:0]), .wb_gpr_we(wwe), .fwd_sel(sel_n)
   );

   function automatic logic [1:0] model(int a, bit b, int m, bit mw, bit ml,
                                        int w, bit ww, bit zhw);
      bit mh, wh;
      if (!b) return 2'b00;
      mh = (a == m) && mw && !(zhw && m == 0);
      if (mh) return ml ? 2'b00 : 2'b10;
      wh = (a == w) && ww && (w != m) && !(zhw && w == 0);
      return wh ? 2'b01 : 2'b00;
   endfunction

   function automatic string tag_of(logic [1:0] e, bit b, bit ml);
      if (!b) return "R1";
      if (e == 2'b10) return "R2";
      if (e == 2'b01) return "R3";
      if (ml) return "R5";
      return "R7";
   endfunction

   task automatic check(string req, string which, logic [1:0] act, logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b (rs=%0d br=%b mrd=%0d mwe=%b mld=%b wrd=%0d wwe=%b)",
                  req, which, act, exp, rs, br, mrd, mwe, mld, wrd, wwe);
      end
   endtask

   task automatic apply(logic [4:0] a, bit b, logic [4:0] m, bit mw, bit ml,
                        logic [4:0] w, bit ww);
      @(posedge clk);
      rs = a; br = b; mrd = m; mwe = mw; mld = ml; wrd = w; wwe = ww;
      @(negedge clk);
   endtask

   task automatic check_both(string req);
      logic [1:0] ew, en;
      ew = model(rs, br, mrd, mwe, mld, wrd, wwe, 1'b1);
      en = model(rs[1:0], br, mrd[1:0], mwe, mld, wrd[1:0], wwe, 1'b0);
      check(req, "wide", sel_w, ew);
      check(req, "narrow", sel_n, en);
   endtask

   initial begin
      rs = '0; br = 1'b0; mrd = '0; mwe = 1'b0; mld = 1'b0; wrd = '0; wwe = 1'b0;
      void'($urandom(32'd20251));
      @(negedge clk);
      check("R1", "reset-idle", sel_w, 2'b00);

      // R1: matches present but not a branch
      apply(5'd7, 1'b0, 5'd7, 1'b1, 1'b0, 5'd9, 1'b1);
      check("R1", "wide", sel_w, 2'b00);
      // R2: memory match
      apply(5'd7, 1'b1, 5'd7, 1'b1, 1'b0, 5'd9, 1'b1);
      check("R2", "wide", sel_w, 2'b10);
      // R3: writeback match
      apply(5'd9, 1'b1, 5'd7, 1'b1, 1'b0, 5'd9, 1'b1);
      check("R3", "wide", sel_w, 2'b01);
      // R5: memory load matches, writeback also holds a different value
      apply(5'd7, 1'b1, 5'd7, 1'b1, 1'b1, 5'd7, 1'b1);
      check("R5", "wide", sel_w, 2'b00);
      apply(5'd6, 1'b1, 5'd6, 1'b1, 1'b1, 5'd3, 1'b1);
      check("R5", "wide", sel_w, 2'b00);
      // R6: writeback shadowed by an idle memory stage with the same rd
      apply(5'd12, 1'b1, 5'd12, 1'b0, 1'b0, 5'd12, 1'b1);
      check("R6", "wide", sel_w, 2'b00);
      // R4: zero destination in both stages
      apply(5'd0, 1'b1, 5'd0, 1'b1, 1'b0, 5'd4, 1'b1);
      check("R4", "wide", sel_w, 2'b00);
      apply(5'd0, 1'b1, 5'd4, 1'b1, 1'b0, 5'd0, 1'b1);
      check("R4", "wide", sel_w, 2'b00);
      // R8: same zero cases forwarded by the narrow copy
      apply(5'd0, 1'b1, 5'd0, 1'b1, 1'b0, 5'd1, 1'b1);
      check("R8", "narrow", sel_n, 2'b10);
      apply(5'd0, 1'b1, 5'd2, 1'b1, 1'b0, 5'd0, 1'b1);
      check("R8", "narrow", sel_n, 2'b01);
      // R3: no write enable in writeback
      apply(5'd9, 1'b1, 5'd7, 1'b1, 1'b0, 5'd9, 1'b0);
      check("R3", "wide", sel_w, 2'b00);

      for (int i = 0; i < 3000; i++) begin
         logic [4:0] a, m, w;
         logic [1:0] ew;
         a = 5'($urandom());
         m = ($urandom() % 3 == 0) ? a : 5'($urandom());
         w = ($urandom() % 3 == 0) ? a : 5'($urandom());
         apply(a, ($urandom() % 4) != 0, m, 1'($urandom()), 1'($urandom()),
               w, 1'($urandom()));
         ew = model(rs, br, mrd, mwe, mld, wrd, wwe, 1'b1);
         check_both(tag_of(ew, br, mld));
         check("R7", "narrow-code", {sel_n == 2'b11, 1'b0}, 2'b00);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule